// File: doc/BRIEF.md
# SD Card Host Initialization Sequencer

This block runs on the host side and takes an SD-mode memory device from power-off to the data-transfer state. It first holds the device supply off for a fixed time, then turns the supply on and waits for it to settle. It then toggles an identification clock for a programmable number of cycles. After that it works through the identify-and-select command series. It hands each command to a separate command-line serializer over a valid/ready request and takes the response back as a one-cycle strobe carrying the response payload.

Along the way the sequencer negotiates the voltage window and polls until the device reports power-up complete. It captures the operating-conditions word, the identification register, the specific-data register and the relative address. It checks the card-type field, makes a deselect/reselect detour to read the specific data, and at the end programs the bus width. Every step has its own error code. A response timeout, a poll budget that runs out or a bad response field ends the run with that code latched. A new start pulse restarts from the power-off phase.

Top module: `sd_init_seq`

## Requirements
- R1: After an accepted `start`, `pwrEn` is low for at least `OFF_CYC` clock cycles and then goes high.
- R2: After `pwrEn` rises, the block waits `RAMP_CYC` cycles. It then gives exactly `DUMMY_CLKS` rising edges on `idClk` before any command. The first command is index 0 with argument 0, and it takes no response.
- R3: The ACMD41 query is sent first with argument 0. The device window in response bits 23:0 is then ANDed with `VOLT_WIN` and resent as bits 23:0 of the ACMD41 argument, with bits 31:24 zero. The block repeats this until response bit 31 is 1, and `ocr` holds that last response. An empty overlap ends with error code 2.
- R4: A missing ACMD41 response ends with error code 1. So does a busy ACMD41 response that arrives once `A41_BUDGET` cycles have passed since the query answer.
- R5: Every application command (41, 13, 6) is preceded by index 55 with argument `{rca,16'h0}`, where `rca` is 0 until it has been captured. A missing index-55 response ends with error code 10.
- R6: The index-2 response is stored whole in `cid`. The index-3 response bits 31:16 are stored in `rca`. A zero address ends with error code 4 and no further command.
- R7: Index 7 with argument `{rca,16'h0}` selects the device. The ACMD13 response carries the card-type field in bits 15:0. Nonzero bits 15:8 end with error code 6.
- R8: After ACMD13 the order is: index 7 with argument 0 (no response), index 9 (payload stored in `csd`), index 10 (payload stored again in `cid`), then index 7 with `{rca,16'h0}`.
- R9: The last command is ACMD6 with argument 2 when `wide4` is 1 and argument 0 otherwise. Its response sets `done`.
- R10: A response not seen within `RSP_TO` cycles of command acceptance ends the run with the code of its step: 1 for ACMD41, 3 for index 2, 4 for index 3, 5 for index 7, 6 for ACMD13, 7 for index 9, 8 for index 10, 9 for ACMD6.
- R11: `done` and `err` are never high together. Each holds until the next `start`. `errCode` is nonzero whenever `err` is high and 0 after reset.
- R12: While `cmdValid` is high and `cmdReady` is low, `cmdValid`, `cmdIndex` and `cmdArg` stay unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin (or restart) the sequence when idle, done or failed |
| wide4 | input | 1 | 1 selects four data lines, 0 selects one |
| pwrEn | output | 1 | Device supply enable |
| idClk | output | 1 | Identification clock during the dummy phase, low otherwise |
| cmdValid | output | 1 | Command request to the serializer |
| cmdIndex | output | 6 | Command index |
| cmdArg | output | 32 | Command argument |
| cmdReady | input | 1 | Serializer accepts the command |
| rspValid | input | 1 | One-cycle strobe: response payload is valid |
| rspData | input | 128 | Response payload, short responses in bits 31:0 |
| done | output | 1 | Device is in the transfer state with bus width set |
| err | output | 1 | Sequence aborted |
| errCode | output | 4 | Code of the failing step |
| ocr | output | 32 | Final operating-conditions response |
| cid | output | 128 | Identification register |
| csd | output | 128 | Specific-data register |
| rca | output | 16 | Relative device address |

## Verification
The bench builds the block with a 20-cycle power-off time, a 30-cycle ramp, the full 74 identification clocks, a 16-cycle response timeout and a 400-cycle poll budget. These short settings keep every power-up phase and both retry limits reachable within a few hundred cycles, so one bench can run a complete successful sequence as well as a poll loop that never finishes and runs out of budget. Because the voltage mask is narrower than the device window, the resent ACMD41 argument shows that masking is applied, and a device window outside the mask gives the empty-overlap error.

// File: rtl/sdi_pkg.sv
package sdi_pkg;

  typedef enum logic [3:0] {
    E_NONE  = 4'd0,
    E_NOTSD = 4'd1,
    E_VOLT  = 4'd2,
    E_CID   = 4'd3,
    E_RCA   = 4'd4,
    E_SEL   = 4'd5,
    E_TYPE  = 4'd6,
    E_CSD   = 4'd7,
    E_CID2  = 4'd8,
    E_WIDTH = 4'd9,
    E_APP   = 4'd10
  } errCodeT;

  typedef enum logic [1:0] {
    A_ZERO,
    A_RCA,
    A_VOLT,
    A_WIDTH
  } argSelT;

  typedef struct packed {
    logic   tmrClr;
    logic   budClr;
    logic   clkRun;
    logic   capOcr;
    logic   capCid;
    logic   capCsd;
    logic   capRca;
    argSelT argSel;
  } dpCtlT;

endpackage

// File: rtl/sdi_dp.sv
module sdi_dp
  import sdi_pkg::*;
#(
  parameter int          TW         = 16,
  parameter int          BW         = 16,
  parameter int          A41_BUDGET = 1000,
  parameter logic [23:0] VOLT_WIN   = 24'hFF8000
) (
  input  logic           clk,
  input  logic           rstN,
  input  dpCtlT          dpCtl,
  input  logic           wide4,
  input  logic [127:0]   rspData,
  output logic [TW-1:0]  tmr,
  output logic           budExp,
  output logic           idClk,
  output logic [31:0]    cmdArg,
  output logic [31:0]    ocr,
  output logic [127:0]   cid,
  output logic [127:0]   csd,
  output logic [15:0]    rca
);

  logic [BW-1:0] bud;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmr   <= '0;
      bud   <= '0;
      idClk <= 1'b0;
      ocr   <= '0;
      cid   <= '0;
      csd   <= '0;
      rca   <= '0;
    end else begin
      if (dpCtl.tmrClr)      tmr <= '0;
      else if (tmr != '1)    tmr <= tmr + 1'b1;
      if (dpCtl.budClr)      bud <= '0;
      else if (bud != '1)    bud <= bud + 1'b1;
      idClk <= dpCtl.clkRun ? ~idClk : 1'b0;
      if (dpCtl.capOcr) ocr <= rspData[31:0];
      if (dpCtl.capCid) cid <= rspData;
      if (dpCtl.capCsd) csd <= rspData;
      if (dpCtl.capRca) rca <= rspData[31:16];
    end
  end

  assign budExp = (bud >= BW'(A41_BUDGET));

  always_comb begin
    unique case (dpCtl.argSel)
      A_RCA:   cmdArg = {rca, 16'h0000};
      A_VOLT:  cmdArg = {8'h00, ocr[23:0] & VOLT_WIN};
      A_WIDTH: cmdArg = {30'd0, wide4, 1'b0};
      default: cmdArg = 32'd0;
    endcase
  end

endmodule

// File: rtl/sdi_ctrl.sv
module sdi_ctrl
  import sdi_pkg::*;
#(
  parameter int          OFF_CYC    = 200,
  parameter int          RAMP_CYC   = 200,
  parameter int          DUMMY_CLKS = 80,
  parameter int          RSP_TO     = 128,
  parameter int          TW         = 16,
  parameter logic [23:0] VOLT_WIN   = 24'hFF8000
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          cmdReady,
  input  logic          rspValid,
  input  logic [31:0]   rsp32,
  input  logic [TW-1:0] tmr,
  input  logic          budExp,
  output dpCtlT         dpCtl,
  output logic          cmdValid,
  output logic [5:0]    cmdIndex,
  output logic          pwrEn,
  output logic          done,
  output logic          err,
  output logic [3:0]    errCode
);

  typedef enum logic [4:0] {
    ST_IDLE, ST_OFF, ST_RAMP, ST_DUMMY, ST_CMD0, ST_A41Q, ST_A41,
    ST_CMD2, ST_CMD3, ST_SEL1, ST_A13, ST_DESEL, ST_CMD9, ST_CMD10,
    ST_SEL2, ST_A6, ST_DONE, ST_ERR
  } stT;

  typedef enum logic [1:0] {PH_APPREQ, PH_APPWAIT, PH_REQ, PH_WAIT} phT;

  localparam int DUM_CYC = 2 * DUMMY_CLKS;

  stT st;
  phT ph;

  function automatic logic isApp(stT s);
    return s inside {ST_A41Q, ST_A41, ST_A13, ST_A6};
  endfunction

  function automatic stT nextOf(stT s);
    case (s)
      ST_CMD0:  return ST_A41Q;
      ST_A41Q:  return ST_A41;
      ST_A41:   return ST_CMD2;
      ST_CMD2:  return ST_CMD3;
      ST_CMD3:  return ST_SEL1;
      ST_SEL1:  return ST_A13;
      ST_A13:   return ST_DESEL;
      ST_DESEL: return ST_CMD9;
      ST_CMD9:  return ST_CMD10;
      ST_CMD10: return ST_SEL2;
      ST_SEL2:  return ST_A6;
      default:  return ST_DONE;
    endcase
  endfunction

  logic [5:0] stepIdx;
  logic       stepRsp;
  argSelT     stepArg;
  errCodeT    stepErr;

  always_comb begin
    stepIdx = 6'd0; stepRsp = 1'b1; stepArg = A_ZERO; stepErr = E_NONE;
    case (st)
      ST_CMD0:  begin stepIdx = 6'd0;  stepRsp = 1'b0; end
      ST_A41Q:  begin stepIdx = 6'd41; stepErr = E_NOTSD; end
      ST_A41:   begin stepIdx = 6'd41; stepArg = A_VOLT; stepErr = E_NOTSD; end
      ST_CMD2:  begin stepIdx = 6'd2;  stepErr = E_CID; end
      ST_CMD3:  begin stepIdx = 6'd3;  stepErr = E_RCA; end
      ST_SEL1:  begin stepIdx = 6'd7;  stepArg = A_RCA; stepErr = E_SEL; end
      ST_A13:   begin stepIdx = 6'd13; stepErr = E_TYPE; end
      ST_DESEL: begin stepIdx = 6'd7;  stepRsp = 1'b0; end
      ST_CMD9:  begin stepIdx = 6'd9;  stepArg = A_RCA; stepErr = E_CSD; end
      ST_CMD10: begin stepIdx = 6'd10; stepArg = A_RCA; stepErr = E_CID2; end
      ST_SEL2:  begin stepIdx = 6'd7;  stepArg = A_RCA; stepErr = E_SEL; end
      ST_A6:    begin stepIdx = 6'd6;  stepArg = A_WIDTH; stepErr = E_WIDTH; end
      default:  ;
    endcase
  end

  logic isCmd, appPh, startAcc, offEnd, rampEnd, dumEnd, rspHit, toHit;

  assign isCmd    = !(st inside {ST_IDLE, ST_OFF, ST_RAMP, ST_DUMMY, ST_DONE, ST_ERR});
  assign appPh    = (ph == PH_APPREQ) || (ph == PH_APPWAIT);
  assign startAcc = start && (st inside {ST_IDLE, ST_DONE, ST_ERR});
  assign offEnd   = (st == ST_OFF)   && (tmr == TW'(OFF_CYC - 1));
  assign rampEnd  = (st == ST_RAMP)  && (tmr == TW'(RAMP_CYC - 1));
  assign dumEnd   = (st == ST_DUMMY) && (tmr == TW'(DUM_CYC - 1));
  assign rspHit   = isCmd && (ph == PH_WAIT) && rspValid;
  assign toHit    = (tmr >= TW'(RSP_TO));

  assign cmdValid = isCmd && ((ph == PH_APPREQ) || (ph == PH_REQ));
  assign cmdIndex = appPh ? 6'd55 : stepIdx;

  always_comb begin
    dpCtl        = '0;
    dpCtl.tmrClr = startAcc || offEnd || rampEnd || dumEnd || (cmdValid && cmdReady);
    dpCtl.budClr = rspHit && (st == ST_A41Q);
    dpCtl.clkRun = (st == ST_DUMMY);
    dpCtl.capOcr = rspHit && (st inside {ST_A41Q, ST_A41});
    dpCtl.capCid = rspHit && (st inside {ST_CMD2, ST_CMD10});
    dpCtl.capCsd = rspHit && (st == ST_CMD9);
    dpCtl.capRca = rspHit && (st == ST_CMD3);
    dpCtl.argSel = appPh ? A_RCA : stepArg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st <= ST_IDLE; ph <= PH_REQ; pwrEn <= 1'b0;
      done <= 1'b0; err <= 1'b0; errCode <= E_NONE;
    end else if (startAcc) begin
      st <= ST_OFF; ph <= PH_REQ; pwrEn <= 1'b0;
      done <= 1'b0; err <= 1'b0; errCode <= E_NONE;
    end else begin
      case (st)
        ST_IDLE, ST_DONE, ST_ERR: ;
        ST_OFF:   if (offEnd)  begin st <= ST_RAMP; pwrEn <= 1'b1; end
        ST_RAMP:  if (rampEnd) st <= ST_DUMMY;
        ST_DUMMY: if (dumEnd)  begin st <= ST_CMD0; ph <= PH_REQ; end
        default: begin
          case (ph)
            PH_APPREQ:  if (cmdReady) ph <= PH_APPWAIT;
            PH_APPWAIT: begin
              if (rspValid) ph <= PH_REQ;
              else if (toHit) begin st <= ST_ERR; err <= 1'b1; errCode <= E_APP; end
            end
            PH_REQ: begin
              if (cmdReady) begin
                if (stepRsp) ph <= PH_WAIT;
                else begin
                  st <= nextOf(st);
                  ph <= isApp(nextOf(st)) ? PH_APPREQ : PH_REQ;
                end
              end
            end
            default: begin
              if (rspValid) begin
                if (st == ST_A41Q && (rsp32[23:0] & VOLT_WIN) == 24'd0) begin
                  st <= ST_ERR; err <= 1'b1; errCode <= E_VOLT;
                end else if (st == ST_A41 && !rsp32[31]) begin
                  if (budExp) begin st <= ST_ERR; err <= 1'b1; errCode <= E_NOTSD; end
                  else ph <= PH_APPREQ;
                end else if (st == ST_CMD3 && rsp32[31:16] == 16'd0) begin
                  st <= ST_ERR; err <= 1'b1; errCode <= E_RCA;
                end else if (st == ST_A13 && rsp32[15:8] != 8'd0) begin
                  st <= ST_ERR; err <= 1'b1; errCode <= E_TYPE;
                end else if (st == ST_A6) begin
                  st <= ST_DONE; done <= 1'b1;
                end else begin
                  st <= nextOf(st);
                  ph <= isApp(nextOf(st)) ? PH_APPREQ : PH_REQ;
                end
              end else if (toHit) begin
                st <= ST_ERR; err <= 1'b1; errCode <= stepErr;
              end
            end
          endcase
        end
      endcase
    end
  end

endmodule

// File: rtl/sd_init_seq.sv
module sd_init_seq
  import sdi_pkg::*;
#(
  parameter int          OFF_CYC    = 200_000,
  parameter int          RAMP_CYC   = 50_000_000,
  parameter int          DUMMY_CLKS = 80,
  parameter int          RSP_TO     = 128,
  parameter int          A41_BUDGET = 200_000_000,
  parameter logic [23:0] VOLT_WIN   = 24'hFF8000
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         wide4,
  output logic         pwrEn,
  output logic         idClk,
  output logic         cmdValid,
  output logic [5:0]   cmdIndex,
  output logic [31:0]  cmdArg,
  input  logic         cmdReady,
  input  logic         rspValid,
  input  logic [127:0] rspData,
  output logic         done,
  output logic         err,
  output logic [3:0]   errCode,
  output logic [31:0]  ocr,
  output logic [127:0] cid,
  output logic [127:0] csd,
  output logic [15:0]  rca
);

  localparam int M1   = (OFF_CYC > RAMP_CYC) ? OFF_CYC : RAMP_CYC;
  localparam int M2   = (2 * DUMMY_CLKS > RSP_TO) ? 2 * DUMMY_CLKS : RSP_TO;
  localparam int TMAX = (M1 > M2) ? M1 : M2;
  localparam int TW   = $clog2(TMAX + 2) + 1;
  localparam int BW   = $clog2(A41_BUDGET + 2) + 1;

  dpCtlT         dpCtl;
  logic [TW-1:0] tmr;
  logic          budExp;

  sdi_ctrl #(
    .OFF_CYC(OFF_CYC), .RAMP_CYC(RAMP_CYC), .DUMMY_CLKS(DUMMY_CLKS),
    .RSP_TO(RSP_TO), .TW(TW), .VOLT_WIN(VOLT_WIN)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .cmdReady(cmdReady),
    .rspValid(rspValid), .rsp32(rspData[31:0]), .tmr(tmr), .budExp(budExp),
    .dpCtl(dpCtl), .cmdValid(cmdValid), .cmdIndex(cmdIndex), .pwrEn(pwrEn),
    .done(done), .err(err), .errCode(errCode)
  );

  sdi_dp #(
    .TW(TW), .BW(BW), .A41_BUDGET(A41_BUDGET), .VOLT_WIN(VOLT_WIN)
  ) i_dp (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .wide4(wide4), .rspData(rspData),
    .tmr(tmr), .budExp(budExp), .idClk(idClk), .cmdArg(cmdArg),
    .ocr(ocr), .cid(cid), .csd(csd), .rca(rca)
  );

endmodule

// File: rtl/sdi_chk.sv
module sdi_chk #(
  parameter int OFF_CYC = 200
) (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic        pwrEn,
  input logic        cmdValid,
  input logic [5:0]  cmdIndex,
  input logic [31:0] cmdArg,
  input logic        cmdReady,
  input logic        done,
  input logic        err,
  input logic [3:0]  errCode,
  input logic [15:0] rca
);

  logic [31:0] offCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              offCnt <= '0;
    else if (pwrEn)         offCnt <= '0;
    else if (offCnt != '1)  offCnt <= offCnt + 1'b1;
  end

  a_r1_pwr_off_hold: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pwrEn) |-> offCnt >= 32'(OFF_CYC));

  a_r2_cmd_needs_power: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> pwrEn);

  a_r7_select_uses_rca: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdIndex == 6'd7 && cmdArg != 32'd0) |-> (cmdArg == {rca, 16'h0000} && rca != 16'd0));

  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(done && err));

  a_r11_code_on_err: assert property (@(posedge clk) disable iff (!rstN)
    err |-> errCode != 4'd0);

  a_r11_done_holds: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);

  a_r12_req_stable: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdReady) |=> (cmdValid && $stable(cmdIndex) && $stable(cmdArg)));

endmodule

bind sd_init_seq sdi_chk #(.OFF_CYC(OFF_CYC)) i_chk (
  .clk(clk), .rstN(rstN), .start(start), .pwrEn(pwrEn), .cmdValid(cmdValid),
  .cmdIndex(cmdIndex), .cmdArg(cmdArg), .cmdReady(cmdReady), .done(done),
  .err(err), .errCode(errCode), .rca(rca)
);

// File: tb/test_sd_init_seq.sv
`timescale 1ns/1ps
module test_sd_init_seq;

  localparam int OFF = 20, RAMP = 30, DCLK = 74, TO = 16, BUD = 400;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, wide4 = 1'b1;
  logic pwrEn, idClk, cmdValid, cmdReady = 1'b0, rspValid = 1'b0;
  logic [5:0] cmdIndex;
  logic [31:0] cmdArg, ocr;
  logic [127:0] rspData = '0, cid, csd;
  logic done, err;
  logic [3:0] errCode;
  logic [15:0] rca;

  always #2.5 clk = ~clk;

  sd_init_seq #(.OFF_CYC(OFF), .RAMP_CYC(RAMP), .DUMMY_CLKS(DCLK), .RSP_TO(TO),
                .A41_BUDGET(BUD), .VOLT_WIN(24'h300000)) i_sd_init_seq (.*);

  localparam logic [127:0] CIDV = 128'h1B53_4D30_3030_3030_10AB_CDEF_0123_4567;
  localparam logic [127:0] CSDV = 128'h400E_0032_5B59_0000_EDC8_7F80_0A40_0001;

  int checks = 0, failures = 0;
  bit finished = 0;
  int busyPolls, dropIdx, a41Cnt, nLog, rises, stabBad;
  logic [15:0] rcaVal;
  logic [7:0]  typeHi;
  logic [23:0] cardWin;
  int logIdx [128];
  logic [31:0] logArg [128];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge idClk) rises++;

  // command-line serializer model
  initial begin
    forever begin
      @(negedge clk);
      if (cmdValid) begin
        int idx;
        logic [31:0] a;
        bit rsp;
        idx = int'(cmdIndex); a = cmdArg;
        if (nLog < 128) begin logIdx[nLog] = idx; logArg[nLog] = a; end
        nLog++;
        repeat (2) begin
          @(negedge clk);
          if (!cmdValid || int'(cmdIndex) != idx || cmdArg != a) stabBad++;
        end
        cmdReady = 1'b1;
        @(negedge clk);
        cmdReady = 1'b0;
        rsp = !(idx == 0 || (idx == 7 && a == 32'd0)) && idx != dropIdx;
        if (rsp) begin
          repeat (3) @(negedge clk);
          case (idx)
            41: if (a == 32'd0) rspData = {104'd0, cardWin};
                else if (a41Cnt < busyPolls) begin a41Cnt++; rspData = {104'd0, cardWin}; end
                else rspData = {96'd0, 8'h80, cardWin};
            2, 10: rspData = CIDV;
            9:     rspData = CSDV;
            3:     rspData = {96'd0, rcaVal, 16'h0500};
            13:    rspData = {112'd0, typeHi, 8'h00};
            default: rspData = 128'h0900;
          endcase
          rspValid = 1'b1;
          @(negedge clk);
          rspValid = 1'b0;
        end
      end
    end
  end

  function automatic int findPos(int idx, int nth);
    int k = 0;
    for (int i = 0; i < nLog && i < 128; i++)
      if (logIdx[i] == idx) begin
        if (k == nth) return i;
        k++;
      end
    return -1;
  endfunction

  int offN, rampN;

  task automatic runSeq(input int busy, input int drop, input logic [15:0] r,
                        input logic [7:0] th, input logic [23:0] win, input logic w4);
    busyPolls = busy; dropIdx = drop; rcaVal = r; typeHi = th; cardWin = win; wide4 = w4;
    a41Cnt = 0; nLog = 0; rises = 0; stabBad = 0; offN = 0; rampN = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!pwrEn) begin @(negedge clk); offN++; end
    while (!idClk) begin @(negedge clk); rampN++; end
    for (int i = 0; i < 3000 && !(done || err); i++) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  task automatic testReset();
    chk(pwrEn == 0 && cmdValid == 0 && idClk == 0, "R1", "reset outputs idle", {pwrEn, cmdValid, idClk}, 0);
    chk(done == 0 && err == 0 && errCode == 0, "R11", "reset status", {done, err, errCode}, 0);
  endtask

  task automatic testNormal();
    int expS [$];
    bit ok;
    int p;
    runSeq(2, -1, 16'hB368, 8'h00, 24'hFF8000, 1'b1);
    chk(offN >= OFF - 1, "R1", "power off hold", offN, OFF - 1);
    chk(rampN >= RAMP, "R2", "ramp wait", rampN, RAMP);
    chk(rises == DCLK, "R2", "identification clock edges", rises, DCLK);
    chk(logIdx[0] == 0 && logArg[0] == 0, "R2", "first command", {logIdx[0], logArg[0]}, 0);
    expS = '{0, 55, 41};
    for (int i = 0; i < 3; i++) begin expS.push_back(55); expS.push_back(41); end
    expS = {expS, 2, 3, 7, 55, 13, 7, 9, 10, 7, 55, 6};
    ok = (nLog == expS.size());
    for (int i = 0; i < expS.size() && ok; i++) ok = (logIdx[i] == expS[i]);
    chk(ok, "R8", "command order", nLog, expS.size());
    chk(logArg[2] == 0, "R3", "ACMD41 query arg", logArg[2], 0);
    chk(logArg[4] == 32'h0030_0000, "R3", "ACMD41 masked arg", logArg[4], 32'h0030_0000);
    chk(ocr == 32'h80FF_8000, "R3", "final ocr", ocr, 32'h80FF_8000);
    chk(logIdx[1] == 55 && logArg[1] == 0, "R5", "app prefix before address", logArg[1], 0);
    p = findPos(13, 0);
    chk(p > 0 && logIdx[p-1] == 55 && logArg[p-1] == 32'hB368_0000, "R5", "app prefix with address",
        (p > 0) ? logArg[p-1] : 0, 32'hB368_0000);
    chk(rca == 16'hB368, "R6", "captured address", rca, 16'hB368);
    chk(cid == CIDV, "R6", "captured cid", cid, CIDV);
    p = findPos(7, 0);
    chk(p >= 0 && logArg[p] == 32'hB368_0000, "R7", "select arg", (p >= 0) ? logArg[p] : 0, 32'hB368_0000);
    p = findPos(7, 1);
    chk(p >= 0 && logArg[p] == 0, "R8", "deselect arg", (p >= 0) ? logArg[p] : 1, 0);
    chk(csd == CSDV, "R8", "captured csd", csd, CSDV);
    p = findPos(6, 0);
    chk(p >= 0 && logArg[p] == 2, "R9", "width arg four lines", (p >= 0) ? logArg[p] : 9, 2);
    chk(done == 1 && err == 0, "R9", "done set", {done, err}, 2'b10);
    chk(stabBad == 0, "R12", "request held until accepted", stabBad, 0);
    repeat (10) @(negedge clk);
    chk(done == 1 && err == 0, "R11", "done holds", {done, err}, 2'b10);
  endtask

  task automatic testOneLine();
    int p;
    runSeq(0, -1, 16'h0001, 8'h00, 24'h300000, 1'b0);
    p = findPos(6, 0);
    chk(p >= 0 && logArg[p] == 0, "R9", "width arg one line", (p >= 0) ? logArg[p] : 9, 0);
    chk(done == 1, "R9", "done one line", done, 1);
  endtask

  task automatic testErr(input int busy, input int drop, input logic [15:0] r, input logic [7:0] th,
                         input logic [23:0] win, input logic [3:0] code, input string req);
    runSeq(busy, drop, r, th, win, 1'b1);
    chk(err == 1 && done == 0 && errCode == code, req, "error code", {err, done, errCode}, {2'b10, code});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testNormal();
    testOneLine();
    testErr(0, -1, 16'h0000, 8'h00, 24'hFF8000, 4'd4, "R6");
    chk(logIdx[nLog-1] == 3, "R6", "no command after zero address", logIdx[nLog-1], 3);
    testErr(0, -1, 16'h1234, 8'h01, 24'hFF8000, 4'd6, "R7");
    testErr(1000, -1, 16'h1234, 8'h00, 24'hFF8000, 4'd1, "R4");
    testErr(0, 41, 16'h1234, 8'h00, 24'hFF8000, 4'd1, "R4");
    testErr(0, -1, 16'h1234, 8'h00, 24'h000080, 4'd2, "R3");
    testErr(0, 55, 16'h1234, 8'h00, 24'hFF8000, 4'd10, "R5");
    testErr(0, 2, 16'h1234, 8'h00, 24'hFF8000, 4'd3, "R10");
    testErr(0, 9, 16'h1234, 8'h00, 24'hFF8000, 4'd7, "R10");
    repeat (10) @(negedge clk);
    chk(err == 1 && errCode == 4'd7, "R11", "error holds", {err, errCode}, {1'b1, 4'd7});
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule